// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Gate

This block derives several groups of clock waveforms from one fast reference clock and lets two asynchronous, active-low stop pins freeze them for power saving. The first stop pin freezes the processor-domain outputs: the processor clocks, the memory clocks and the interrupt-controller clocks. The second stop pin freezes the peripheral-bus clocks. One member of each processor-domain group, and two members of the bus group, run freely and ignore the stop pins.

Each stop pin passes through a two-stage synchronizer in the reference domain. A group's gate register may load a new value only on a reference cycle whose next divided phase is low. A gated output therefore always finishes its current high phase, parks at 0, and restarts with a high phase of full nominal width. No runt pulse can appear. A per-output enable bit passes through the same low-phase gate, so enabling or disabling an output is also free of glitches. A float bit drops the shared pad drive enable, and the pads outside the block then go to high impedance.

Top module: `clk_stop_gate`

## Requirements
- R1: While reset is held, every clock output is 0 and `pad_oe_o` is 1.
- R2: Every running output toggles with a 50 % duty cycle. Processor and memory outputs have a high phase of CPU_HALF reference cycles (default 2, period 4). Interrupt-controller outputs have APIC_HALF (default 3, period 6). Bus outputs have PCI_HALF (default 4, period 8). All running outputs of one group are in phase.
- R3: Once `cpu_stop_ni` has been low for 4 processor clock periods (16 reference cycles), processor outputs 1 and up, memory outputs 1 and up and interrupt-controller outputs 1 and up are all 0. They stay 0 while the pin stays low.
- R4: Processor output 0, memory output 0 and interrupt-controller output 0 keep toggling while `cpu_stop_ni` is low.
- R5: After `cpu_stop_ni` returns high, the gated processor outputs rise again within 4 processor periods. Their first high pulse lasts the full CPU_HALF cycles.
- R6: After `pci_stop_ni` falls, each gated bus output (index 2 and up) produces at most one more rising edge, then stays 0. Bus outputs 0 and 1 keep toggling.
- R7: After `pci_stop_ni` rises, a gated bus output rises no later than the second rising edge of bus output 0 (counting the one that coincides with it). Its first high pulse lasts PCI_HALF cycles.
- R8: No output ever shows a high pulse other than its nominal half period, or a low pulse shorter than it. A gated output rises only when its group's divided phase rises, and falls only when that phase falls.
- R9: The two stop pins act independently. Freezing one group leaves the other group's outputs toggling.
- R10: An output whose enable bit is 0 stays at 0, free-running members included. Enable bit positions: `out_en_i[2:0]` processor, `[7:3]` memory, `[9:8]` interrupt controller, `[16:10]` bus (bit 10 is bus output 0).
- R11: `pad_oe_o` is 0 from the first reference edge at which `float_i` is sampled 1, and is 1 from the first edge at which `float_i` is sampled 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_stop_ni | input | 1 | Asynchronous request to freeze the processor-domain groups, active low |
| pci_stop_ni | input | 1 | Asynchronous request to freeze the bus group, active low |
| out_en_i | input | N_OUT (17) | Per-output enable, 0 holds the output low |
| float_i | input | 1 | 1 requests high impedance on every output pad |
| cpu_clk_o | output | N_CPU (3) | Processor clocks, bit 0 free-running |
| mem_clk_o | output | N_MEM (5) | Memory clocks, bit 0 free-running |
| apic_clk_o | output | N_APIC (2) | Interrupt-controller clocks, bit 0 free-running |
| pci_clk_o | output | N_PCI (7) | Bus clocks, bits 0 and 1 free-running |
| pad_oe_o | output | 1 | Shared pad drive enable, 0 means float |

## Verification
The bench stops the processor domain alone, the bus domain alone, and then both at once with only the bus domain released. These runs separate a correct gate from one that crosses groups or exempts the wrong outputs. Stop and release edges land at arbitrary phases of the divided clocks. The latency counts and first-pulse widths then show whether gate changes are held back to a low phase. Enable patterns that clear a gated bit and a free-running bit show that enables reach every output, and a free-running output is not exempt from them. Throughout the run, a pulse-width monitor on every output catches any shortened high or low phase.

// File: rtl/csg_pkg.sv
package csg_pkg;

    // Minimum depth of a stop-pin synchronizer.
    localparam int unsigned SYNC_MIN = 2;

    // True on the last count of a half period of length lim.
    function automatic logic half_done(input int unsigned cnt, input int unsigned lim);
        return (cnt == lim - 1);
    endfunction

endpackage

// File: rtl/csg_sync.sv
module csg_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{sh: {STAGES{RST_VAL}}};
        else         st_q <= st_d;
    end

    assign sync_o = st_q.sh[STAGES-1];
endmodule

// File: rtl/csg_div.sv
module csg_div
    import csg_pkg::*;
#(
    parameter int unsigned HALF = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic ph_o,
    output logic ph_next_o
);
    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ph;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (half_done(32'(st_q.cnt), HALF)) begin
            st_d.cnt = '0;
            st_d.ph  = ~st_q.ph;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{cnt: '0, ph: 1'b0};
        else         st_q <= st_d;
    end

    assign ph_o      = st_q.ph;
    assign ph_next_o = st_d.ph;
endmodule

// File: rtl/csg_group.sv
module csg_group #(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned FREE  = 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ph_next_i,
    input  logic             run_i,
    input  logic [WIDTH-1:0] en_i,
    output logic [WIDTH-1:0] clk_o
);
    typedef struct packed {
        logic [WIDTH-1:0] gate;
        logic [WIDTH-1:0] out;
    } grp_st_t;

    grp_st_t          st_d, st_q;
    logic [WIDTH-1:0] want;

    // Free-running members see only their enable; the others also need run_i.
    for (genvar i = 0; i < WIDTH; i++) begin : g_want
        if (i < FREE) begin : g_free
            assign want[i] = en_i[i];
        end else begin : g_stop
            assign want[i] = en_i[i] & run_i;
        end
    end

    always_comb begin
        st_d = st_q;
        // Gate loads only when the coming phase is low: no partial pulses.
        if (!ph_next_i) st_d.gate = want;
        st_d.out = {WIDTH{ph_next_i}} & st_d.gate;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{gate: '0, out: '0};
        else         st_q <= st_d;
    end

    assign clk_o = st_q.out;
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
    import csg_pkg::*;
#(
    parameter int unsigned N_CPU     = 3,
    parameter int unsigned N_MEM     = 5,
    parameter int unsigned N_APIC    = 2,
    parameter int unsigned N_PCI     = 7,
    parameter int unsigned PCI_FREE  = 2,
    parameter int unsigned CPU_HALF  = 2,
    parameter int unsigned APIC_HALF = 3,
    parameter int unsigned PCI_HALF  = 4,
    parameter int unsigned SYNC_LEN  = SYNC_MIN,
    localparam int unsigned N_OUT    = N_CPU + N_MEM + N_APIC + N_PCI
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cpu_stop_ni,
    input  logic              pci_stop_ni,
    input  logic [N_OUT-1:0]  out_en_i,
    input  logic              float_i,
    output logic [N_CPU-1:0]  cpu_clk_o,
    output logic [N_MEM-1:0]  mem_clk_o,
    output logic [N_APIC-1:0] apic_clk_o,
    output logic [N_PCI-1:0]  pci_clk_o,
    output logic              pad_oe_o
);
    localparam int unsigned OFS_MEM  = N_CPU;
    localparam int unsigned OFS_APIC = OFS_MEM + N_MEM;
    localparam int unsigned OFS_PCI  = OFS_APIC + N_APIC;

    typedef struct packed {
        logic hiz;
    } top_st_t;

    top_st_t st_d, st_q;

    logic cpu_run, pci_run;
    logic cpu_ph, cpu_ph_next;
    logic apic_ph, apic_ph_next;
    logic pci_ph, pci_ph_next;

    csg_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_cpu_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .async_i(cpu_stop_ni), .sync_o(cpu_run)
    );
    csg_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_pci_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .async_i(pci_stop_ni), .sync_o(pci_run)
    );

    csg_div #(.HALF(CPU_HALF)) u_cpu_div (
        .clk_i(clk_i), .rst_ni(rst_ni), .ph_o(cpu_ph), .ph_next_o(cpu_ph_next)
    );
    csg_div #(.HALF(APIC_HALF)) u_apic_div (
        .clk_i(clk_i), .rst_ni(rst_ni), .ph_o(apic_ph), .ph_next_o(apic_ph_next)
    );
    csg_div #(.HALF(PCI_HALF)) u_pci_div (
        .clk_i(clk_i), .rst_ni(rst_ni), .ph_o(pci_ph), .ph_next_o(pci_ph_next)
    );

    csg_group #(.WIDTH(N_CPU), .FREE(1)) u_cpu_grp (
        .clk_i(clk_i), .rst_ni(rst_ni), .ph_next_i(cpu_ph_next), .run_i(cpu_run),
        .en_i(out_en_i[N_CPU-1:0]), .clk_o(cpu_clk_o)
    );
    csg_group #(.WIDTH(N_MEM), .FREE(1)) u_mem_grp (
        .clk_i(clk_i), .rst_ni(rst_ni), .ph_next_i(cpu_ph_next), .run_i(cpu_run),
        .en_i(out_en_i[OFS_MEM +: N_MEM]), .clk_o(mem_clk_o)
    );
    csg_group #(.WIDTH(N_APIC), .FREE(1)) u_apic_grp (
        .clk_i(clk_i), .rst_ni(rst_ni), .ph_next_i(apic_ph_next), .run_i(cpu_run),
        .en_i(out_en_i[OFS_APIC +: N_APIC]), .clk_o(apic_clk_o)
    );
    csg_group #(.WIDTH(N_PCI), .FREE(PCI_FREE)) u_pci_grp (
        .clk_i(clk_i), .rst_ni(rst_ni), .ph_next_i(pci_ph_next), .run_i(pci_run),
        .en_i(out_en_i[OFS_PCI +: N_PCI]), .clk_o(pci_clk_o)
    );

    always_comb begin
        st_d     = st_q;
        st_d.hiz = float_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{hiz: 1'b0};
        else         st_q <= st_d;
    end

    assign pad_oe_o = ~st_q.hiz;
endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk #(
    parameter int unsigned N_CPU    = 3,
    parameter int unsigned N_MEM    = 5,
    parameter int unsigned N_APIC   = 2,
    parameter int unsigned N_PCI    = 7,
    parameter int unsigned CPU_HALF = 2
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cpu_stop_ni,
    input logic              float_i,
    input logic              pad_oe_o,
    input logic [N_CPU-1:0]  cpu_clk_o,
    input logic [N_MEM-1:0]  mem_clk_o,
    input logic [N_APIC-1:0] apic_clk_o,
    input logic [N_PCI-1:0]  pci_clk_o,
    input logic              cpu_ph,
    input logic              apic_ph,
    input logic              pci_ph
);
    localparam int unsigned OFF_LIM = 8 * CPU_HALF;
    localparam int unsigned LW      = $clog2(OFF_LIM + 1);

    logic [LW-1:0] low_cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                    low_cnt_q <= '0;
        else if (cpu_stop_ni)           low_cnt_q <= '0;
        else if (low_cnt_q != LW'(OFF_LIM)) low_cnt_q <= low_cnt_q + 1'b1;
    end

    // R3: after four processor periods of stop, every gated processor-domain output is parked low
    p_cpu_off_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (low_cnt_q == LW'(OFF_LIM)) |->
            (cpu_clk_o[N_CPU-1:1] == '0 && mem_clk_o[N_MEM-1:1] == '0 && apic_clk_o[N_APIC-1:1] == '0));

    // R11: float request reaches the pad enable after one edge
    p_float_on_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        float_i |=> !pad_oe_o);
    p_float_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !float_i |=> pad_oe_o);

    // R8: outputs move only together with their group's divided phase
    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
        p_cpu_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(cpu_clk_o[i]) |-> $rose(cpu_ph));
        p_cpu_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(cpu_clk_o[i]) |-> $fell(cpu_ph));
    end
    for (genvar i = 0; i < N_MEM; i++) begin : g_mem
        p_mem_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(mem_clk_o[i]) |-> $rose(cpu_ph));
        p_mem_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(mem_clk_o[i]) |-> $fell(cpu_ph));
    end
    for (genvar i = 0; i < N_APIC; i++) begin : g_apic
        p_apic_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(apic_clk_o[i]) |-> $rose(apic_ph));
        p_apic_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(apic_clk_o[i]) |-> $fell(apic_ph));
    end
    for (genvar i = 0; i < N_PCI; i++) begin : g_pci
        p_pci_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(pci_clk_o[i]) |-> $rose(pci_ph));
        p_pci_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(pci_clk_o[i]) |-> $fell(pci_ph));
    end
endmodule

bind clk_stop_gate clk_stop_gate_chk #(
    .N_CPU(N_CPU), .N_MEM(N_MEM), .N_APIC(N_APIC), .N_PCI(N_PCI), .CPU_HALF(CPU_HALF)
) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .cpu_stop_ni(cpu_stop_ni), .float_i(float_i),
    .pad_oe_o(pad_oe_o), .cpu_clk_o(cpu_clk_o), .mem_clk_o(mem_clk_o),
    .apic_clk_o(apic_clk_o), .pci_clk_o(pci_clk_o),
    .cpu_ph(cpu_ph), .apic_ph(apic_ph), .pci_ph(pci_ph)
);

// File: tb/sim_clk_stop_gate.sv
`timescale 1ns/1ps
module sim_clk_stop_gate;
    localparam int N_CPU = 3, N_MEM = 5, N_APIC = 2, N_PCI = 7;
    localparam int N_OUT = N_CPU + N_MEM + N_APIC + N_PCI;
    localparam int CH = 2, AH = 3, PH = 4;
    // Indices into the flat output vector {pci, apic, mem, cpu}
    localparam int I_CPU0 = 0, I_CPU1 = 1, I_CPU2 = 2;
    localparam int I_MEM0 = 3, I_MEM1 = 4;
    localparam int I_APIC0 = 8, I_APIC1 = 9;
    localparam int I_PCI0 = 10, I_PCI1 = 11, I_PCI2 = 12, I_PCI3 = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_stop_n = 1'b1;
    logic pci_stop_n = 1'b1;
    logic [N_OUT-1:0] en = '1;
    logic flt = 1'b0;
    logic [N_CPU-1:0]  cpu_o;
    logic [N_MEM-1:0]  mem_o;
    logic [N_APIC-1:0] apic_o;
    logic [N_PCI-1:0]  pci_o;
    logic              oe;
    logic [N_OUT-1:0]  all_o;

    int n_chk = 0, n_bad = 0, runts = 0;
    bit mon_on = 1'b0, done = 1'b0;

    always #10 clk = ~clk;

    clk_stop_gate u0 (
        .clk_i(clk), .rst_ni(rst_n), .cpu_stop_ni(cpu_stop_n), .pci_stop_ni(pci_stop_n),
        .out_en_i(en), .float_i(flt), .cpu_clk_o(cpu_o), .mem_clk_o(mem_o),
        .apic_clk_o(apic_o), .pci_clk_o(pci_o), .pad_oe_o(oe)
    );

    assign all_o = {pci_o, apic_o, mem_o, cpu_o};

    function automatic int half_of(input int k);
        if (k < N_CPU + N_MEM) return CH;
        if (k < N_CPU + N_MEM + N_APIC) return AH;
        return PH;
    endfunction

    // R8 pulse-width monitor over every output
    logic [N_OUT-1:0] prev_o = '0;
    int hi_len [N_OUT];
    int lo_len [N_OUT];
    always @(negedge clk) begin
        if (mon_on) begin
            for (int k = 0; k < N_OUT; k++) begin
                if (all_o[k]) begin
                    if (!prev_o[k]) begin
                        if (lo_len[k] < half_of(k)) runts++;
                        hi_len[k] = 1;
                    end else hi_len[k]++;
                end else begin
                    if (prev_o[k]) begin
                        if (hi_len[k] != half_of(k)) runts++;
                        lo_len[k] = 1;
                    end else lo_len[k]++;
                end
            end
        end else begin
            for (int k = 0; k < N_OUT; k++) begin
                hi_len[k] = 0;
                lo_len[k] = 1000;
            end
        end
        prev_o = all_o;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Wait for a rising edge on output k, then measure high samples and full period.
    task automatic measure(input int k, output int hi, output int per);
        logic p;
        hi = 0; per = 0;
        @(negedge clk); p = all_o[k];
        for (int t = 0; t < 100; t++) begin
            @(negedge clk);
            if (all_o[k] && !p) break;
            p = all_o[k];
        end
        hi = 1; per = 1;
        for (int t = 0; t < 100; t++) begin
            @(negedge clk);
            if (!all_o[k]) break;
            hi++; per++;
        end
        for (int t = 0; t < 100; t++) begin
            per++;
            @(negedge clk);
            if (all_o[k]) break;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(all_o == '0, "R1 outputs low in reset", int'(all_o), 0);
        check(oe == 1'b1, "R1 pad enable in reset", int'(oe), 1);
        rst_n = 1'b1;
        mon_on = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic t_rates();
        int hi, per, diff;
        measure(I_CPU1, hi, per);
        check(hi == CH && per == 2 * CH, "R2 cpu period", per * 100 + hi, 2 * CH * 100 + CH);
        measure(I_APIC1, hi, per);
        check(hi == AH && per == 2 * AH, "R2 apic period", per * 100 + hi, 2 * AH * 100 + AH);
        measure(I_PCI3, hi, per);
        check(hi == PH && per == 2 * PH, "R2 pci period", per * 100 + hi, 2 * PH * 100 + PH);
        diff = 0;
        for (int t = 0; t < 16; t++) begin
            @(negedge clk);
            if (cpu_o[0] != cpu_o[2] || mem_o[0] != mem_o[4] || pci_o[0] != pci_o[6]) diff++;
        end
        check(diff == 0, "R2 group members in phase", diff, 0);
    endtask

    task automatic t_cpu_stop();
        int bad, r_cpu, r_mem, r_apic, r_pci, wait_c, hi;
        logic [N_OUT-1:0] p;
        @(negedge clk);
        cpu_stop_n = 1'b0;
        repeat (16) @(negedge clk);
        bad = 0; r_cpu = 0; r_mem = 0; r_apic = 0; r_pci = 0;
        p = all_o;
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            if (cpu_o[N_CPU-1:1] != '0 || mem_o[N_MEM-1:1] != '0 || apic_o[1] != 1'b0) bad++;
            if (all_o[I_CPU0] && !p[I_CPU0]) r_cpu++;
            if (all_o[I_MEM0] && !p[I_MEM0]) r_mem++;
            if (all_o[I_APIC0] && !p[I_APIC0]) r_apic++;
            if (all_o[I_PCI2] && !p[I_PCI2]) r_pci++;
            p = all_o;
        end
        check(bad == 0, "R3 cpu-domain gated outputs parked low", bad, 0);
        check(r_cpu >= 9, "R4 free cpu output toggles", r_cpu, 10);
        check(r_mem >= 9, "R4 free mem output toggles", r_mem, 10);
        check(r_apic >= 6, "R4 free apic output toggles", r_apic, 6);
        check(r_pci >= 4, "R9 pci group unaffected by cpu stop", r_pci, 5);
        @(negedge clk);
        cpu_stop_n = 1'b1;
        wait_c = 0;
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            wait_c++;
            if (cpu_o[1]) break;
        end
        check(wait_c <= 16, "R5 cpu on latency (ref cycles)", wait_c, 16);
        hi = 1;
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            if (!cpu_o[1]) break;
            hi++;
        end
        check(hi == CH, "R5 first cpu pulse full width", hi, CH);
        repeat (12) @(negedge clk);
    endtask

    task automatic t_pci_stop();
        int r_after, bad, r_f0, r_f1, r_cpu, cnt0, hi;
        logic [N_OUT-1:0] p;
        @(negedge clk);
        pci_stop_n = 1'b0;
        p = all_o;
        r_after = 0;
        for (int t = 0; t < 24; t++) begin
            @(negedge clk);
            if (all_o[I_PCI2] && !p[I_PCI2]) r_after++;
            p = all_o;
        end
        check(r_after <= 1, "R6 at most one rising edge after pci stop", r_after, 1);
        bad = 0; r_f0 = 0; r_f1 = 0; r_cpu = 0;
        for (int t = 0; t < 32; t++) begin
            @(negedge clk);
            if (pci_o[N_PCI-1:2] != '0) bad++;
            if (all_o[I_PCI0] && !p[I_PCI0]) r_f0++;
            if (all_o[I_PCI1] && !p[I_PCI1]) r_f1++;
            if (all_o[I_CPU1] && !p[I_CPU1]) r_cpu++;
            p = all_o;
        end
        check(bad == 0, "R6 gated pci outputs parked low", bad, 0);
        check(r_f0 >= 3 && r_f1 >= 3, "R6 pci outputs 0 and 1 keep toggling", r_f0 + r_f1, 8);
        check(r_cpu >= 7, "R9 cpu group unaffected by pci stop", r_cpu, 8);
        @(negedge clk);
        pci_stop_n = 1'b1;
        p = all_o;
        cnt0 = 0;
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            if (all_o[I_PCI0] && !p[I_PCI0]) cnt0++;
            p = all_o;
            if (pci_o[2]) break;
        end
        check(pci_o[2] && cnt0 <= 2, "R7 pci restart by second reference rise", cnt0, 2);
        hi = 1;
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            if (!pci_o[2]) break;
            hi++;
        end
        check(hi == PH, "R7 first pci pulse full width", hi, PH);
        repeat (12) @(negedge clk);
    endtask

    task automatic t_enable();
        int bad, r1, w;
        @(negedge clk);
        en[I_CPU2] = 1'b0;
        en[I_PCI0] = 1'b0;
        repeat (12) @(negedge clk);
        bad = 0; r1 = 0;
        for (int t = 0; t < 24; t++) begin
            logic q = cpu_o[1];
            @(negedge clk);
            if (cpu_o[2]) bad++;
            if (cpu_o[1] && !q) r1++;
        end
        check(bad == 0, "R10 disabled gated cpu output held low", bad, 0);
        bad = 0;
        for (int t = 0; t < 24; t++) begin
            @(negedge clk);
            if (pci_o[0]) bad++;
        end
        check(bad == 0, "R10 disabled free pci output held low", bad, 0);
        check(r1 >= 5, "R10 neighbour keeps running", r1, 6);
        en[I_CPU2] = 1'b1;
        en[I_PCI0] = 1'b1;
        w = 0;
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            w++;
            if (cpu_o[2]) break;
        end
        check(cpu_o[2] == 1'b1, "R10 re-enabled output runs", w, 8);
        repeat (12) @(negedge clk);
    endtask

    task automatic t_float();
        @(negedge clk);
        flt = 1'b1;
        @(negedge clk);
        check(oe == 1'b0, "R11 pad enable drops", int'(oe), 0);
        flt = 1'b0;
        @(negedge clk);
        check(oe == 1'b1, "R11 pad enable returns", int'(oe), 1);
    endtask

    task automatic t_both();
        int bad, r3;
        logic [N_OUT-1:0] p;
        @(negedge clk);
        cpu_stop_n = 1'b0;
        pci_stop_n = 1'b0;
        repeat (30) @(negedge clk);
        pci_stop_n = 1'b1;
        repeat (30) @(negedge clk);
        bad = 0; r3 = 0;
        p = all_o;
        for (int t = 0; t < 24; t++) begin
            @(negedge clk);
            if (cpu_o[1]) bad++;
            if (all_o[I_PCI3] && !p[I_PCI3]) r3++;
            p = all_o;
        end
        check(bad == 0 && r3 >= 2, "R9 pci released while cpu held", r3 * 100 + bad, 300);
        cpu_stop_n = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_rates();
        t_cpu_stop();
        t_pci_stop();
        t_enable();
        t_float();
        t_both();
        check(runts == 0, "R8 no runt pulses on any output", runts, 0);
        finish_run();
    end

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end
endmodule